// File: doc/BRIEF.md
# I2C Paired-Register GPIO Target

This block is an I2C/SMBus target that fronts a 16-bit general-purpose I/O expander. It owns eight byte-wide registers arranged as four pairs: the sampled pin levels, the output latches, the input polarity inversion masks and the direction masks. A bus master writes a command byte that acts as a register pointer. It then streams data bytes into the registers, or it issues a repeated START and reads them back.

Both reads and writes advance the pointer in an unusual way. After every data byte the pointer moves to the other register of the same pair, so a stream alternates between the two ports with no length limit. SCL and SDA arrive as sampled inputs on the system clock. The target pulls SDA low through a single output enable. The output, polarity and direction registers are driven straight out toward the pad logic of the port.

Top module: `gpx_i2c_target`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits equal 1,1,1,0,1,strap[1],strap[0]. It leaves any other address unacknowledged and ignores the rest of that transfer. Bit 0 of the address byte is 1 for a read and 0 for a write.
- R2: The first byte after a write address is the command. Only its bits [2:0] choose the register, and bits [7:3] are ignored. Index 0 is pins[7:0] and index 1 is pins[15:8]. Index 2 is out_q[7:0] and index 3 is out_q[15:8]. Index 4 is pol_q[7:0] and index 5 is pol_q[15:8]. Index 6 is cfg_q[7:0] and index 7 is cfg_q[15:8].
- R3: Each written data byte updates exactly one register. The pointer then flips bit 0 (3→2→3…), and there is no limit on the byte count.
- R4: A write address, a command, a repeated START and then a read address return the selected register first. Each following byte comes from the other register of the pair, alternately.
- R5: Data written to index 0 or 1 changes no register, although the pointer still alternates.
- R6: While rst_n is low, out_q reads 0xFFFF, pol_q reads 0x0000 and cfg_q reads 0xFFFF, and sda_oe is low.
- R7: Reading index 0 or 1 returns the synchronized pin byte XOR the matching polarity byte.
- R8: Reading index 2 to 7 returns the stored register value whatever the pin levels are.
- R9: A STOP after any byte ends the transfer. The next transfer must send a fresh command, and register changes only take effect while SCL is low.
- R10: Pulling rst_n low in the middle of a transfer restores the defaults and returns the bus logic to idle.
- R11: The target changes sda_oe only while SCL is low. It acknowledges the address, the command and every written byte, and it stops streaming read data after the master NACKs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| strap_i | input | 2 | Address strap bits {A1,A0} |
| pin_i | input | 16 | Port pin levels |
| out_q | output | 16 | Output latch register pair |
| pol_q | output | 16 | Input polarity inversion pair |
| cfg_q | output | 16 | Direction pair, 1 = input |

## Verification
Random transfers start at every register index, with and without junk in the upper command bits, and stream one to five bytes. This separates a pointer that flips inside its pair from one that counts linearly or does not move. Reads are interleaved with random pin changes and random polarity masks. This distinguishes the inverted input path from the stored-value path of the other registers. Directed cases cover a strap mismatch, writes aimed at the input registers, a STOP followed by a fresh command, and reset asserted halfway through a byte. Each of these shows whether state leaks across transfer boundaries.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
   localparam int unsigned BYTE_BITS = 8;
   localparam int unsigned IDX_W     = 3;

   localparam logic [1:0] GRP_IN  = 2'd0;
   localparam logic [1:0] GRP_OUT = 2'd1;
   localparam logic [1:0] GRP_POL = 2'd2;
   localparam logic [1:0] GRP_CFG = 2'd3;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_CMD, ST_CMD_ACK,
      ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
   } bus_st_e;

   typedef struct packed {
      logic                 valid;
      logic [IDX_W-1:0]     idx;
      logic [BYTE_BITS-1:0] data;
   } wr_req_t;
endpackage

// File: rtl/gpx_sync.sv
module gpx_sync #(
   parameter int unsigned W       = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("gpx_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(STAGES); i++) stage_q[i] <= RST_VAL;
      end else begin
         stage_q[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpx_bus_fsm.sv
module gpx_bus_fsm
   import gpx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 scl_s,
   input  logic                 sda_s,
   input  logic [6:0]           dev_addr,
   input  logic [BYTE_BITS-1:0] rd_data,
   output wr_req_t              wr,
   output logic [IDX_W-1:0]     ptr,
   output logic                 sda_oe
);
   localparam logic [3:0] LAST_BIT = 4'(BYTE_BITS);

   bus_st_e              state;
   logic                 scl_d, sda_d;
   logic [3:0]           bitcnt;
   logic [BYTE_BITS-1:0] shreg;
   logic [BYTE_BITS-1:0] txreg;
   logic                 rd_mode;
   logic                 mack;

   logic scl_rise, scl_fall, start_det, stop_det, byte_done;

   assign scl_rise  = scl_s & ~scl_d;
   assign scl_fall  = ~scl_s & scl_d;
   assign start_det = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
   assign byte_done = scl_fall && (bitcnt == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         scl_d   <= 1'b1;
         sda_d   <= 1'b1;
         bitcnt  <= '0;
         shreg   <= '0;
         txreg   <= '0;
         rd_mode <= 1'b0;
         mack    <= 1'b0;
         ptr     <= '0;
         sda_oe  <= 1'b0;
         wr      <= '0;
      end else begin
         scl_d    <= scl_s;
         sda_d    <= sda_s;
         wr.valid <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            bitcnt <= '0;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_CMD, ST_WR: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[BYTE_BITS-2:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     if (state == ST_ADDR) begin
                        if (shreg[7:1] == dev_addr) begin
                           rd_mode <= shreg[0];
                           sda_oe  <= 1'b1;
                           state   <= ST_ADDR_ACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else if (state == ST_CMD) begin
                        ptr    <= shreg[IDX_W-1:0];
                        sda_oe <= 1'b1;
                        state  <= ST_CMD_ACK;
                     end else begin
                        wr     <= '{valid: 1'b1, idx: ptr, data: shreg};
                        ptr    <= {ptr[IDX_W-1:1], ~ptr[0]};
                        sda_oe <= 1'b1;
                        state  <= ST_WR_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rd_mode) begin
                        txreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_BITS-1];
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_CMD;
                     end
                  end
               end
               ST_CMD_ACK, ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bitcnt <= bitcnt + 4'd1;
                  end else if (byte_done) begin
                     bitcnt <= '0;
                     sda_oe <= 1'b0;
                     ptr    <= {ptr[IDX_W-1:1], ~ptr[0]};
                     state  <= ST_RD_ACK;
                  end else if (scl_fall) begin
                     txreg  <= {txreg[BYTE_BITS-2:0], 1'b0};
                     sda_oe <= ~txreg[BYTE_BITS-2];
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack) begin
                        txreg  <= rd_data;
                        sda_oe <= ~rd_data[BYTE_BITS-1];
                        state  <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/gpx_regfile.sv
module gpx_regfile
   import gpx_pkg::*;
#(
   parameter int unsigned PORT_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  wr_req_t              wr,
   input  logic [IDX_W-1:0]     rd_idx,
   input  logic [PORT_W-1:0]    pin_s,
   output logic [BYTE_BITS-1:0] rd_data,
   output logic [PORT_W-1:0]    out_q,
   output logic [PORT_W-1:0]    pol_q,
   output logic [PORT_W-1:0]    cfg_q
);
   localparam int unsigned NPORT = PORT_W / BYTE_BITS;

   logic [BYTE_BITS-1:0] in_byte  [NPORT];
   logic [BYTE_BITS-1:0] out_byte [NPORT];
   logic [BYTE_BITS-1:0] pol_byte [NPORT];
   logic [BYTE_BITS-1:0] cfg_byte [NPORT];

   for (genvar p = 0; p < int'(NPORT); p++) begin : g_port
      localparam logic PSEL = 1'(p);
      logic [BYTE_BITS-1:0] out_r, pol_r, cfg_r;
      logic                 hit;

      assign hit = wr.valid && (wr.idx[0] == PSEL);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_r <= '1;
            pol_r <= '0;
            cfg_r <= '1;
         end else if (hit) begin
            unique case (wr.idx[2:1])
               GRP_OUT: out_r <= wr.data;
               GRP_POL: pol_r <= wr.data;
               GRP_CFG: cfg_r <= wr.data;
               default: ;
            endcase
         end
      end

      assign in_byte[p]  = pin_s[p*BYTE_BITS +: BYTE_BITS] ^ pol_r;
      assign out_byte[p] = out_r;
      assign pol_byte[p] = pol_r;
      assign cfg_byte[p] = cfg_r;
      assign out_q[p*BYTE_BITS +: BYTE_BITS] = out_r;
      assign pol_q[p*BYTE_BITS +: BYTE_BITS] = pol_r;
      assign cfg_q[p*BYTE_BITS +: BYTE_BITS] = cfg_r;
   end

   always_comb begin
      unique case (rd_idx[2:1])
         GRP_IN:  rd_data = in_byte[rd_idx[0]];
         GRP_OUT: rd_data = out_byte[rd_idx[0]];
         GRP_POL: rd_data = pol_byte[rd_idx[0]];
         default: rd_data = cfg_byte[rd_idx[0]];
      endcase
   end
endmodule

// File: rtl/gpx_i2c_target.sv
module gpx_i2c_target
   import gpx_pkg::*;
#(
   parameter logic [4:0]  ADDR_HI     = 5'b11101,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PORT_W      = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        strap_i,
   input  logic [PORT_W-1:0] pin_i,
   output logic [PORT_W-1:0] out_q,
   output logic [PORT_W-1:0] pol_q,
   output logic [PORT_W-1:0] cfg_q
);
   localparam int unsigned NPORT = PORT_W / BYTE_BITS;

   if (NPORT != 2 || (PORT_W % BYTE_BITS) != 0) begin : g_bad_width
      $error("gpx_i2c_target: PORT_W must be two bytes");
   end

   logic [1:0]           bus_s;
   logic [PORT_W-1:0]    pin_s;
   wr_req_t              wr;
   logic [IDX_W-1:0]     ptr;
   logic [BYTE_BITS-1:0] rd_data;

   gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

   gpx_sync #(.W(PORT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s));

   gpx_bus_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
      .dev_addr({ADDR_HI, strap_i}), .rd_data(rd_data),
      .wr(wr), .ptr(ptr), .sda_oe(sda_oe));

   gpx_regfile #(.PORT_W(PORT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(wr), .rd_idx(ptr), .pin_s(pin_s),
      .rd_data(rd_data), .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q));
endmodule

// File: rtl/gpx_i2c_target_chk.sv
module gpx_i2c_target_chk #(
   parameter int unsigned PORT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_oe,
   input logic [PORT_W-1:0] out_q,
   input logic [PORT_W-1:0] pol_q,
   input logic [PORT_W-1:0] cfg_q
);
   localparam int unsigned HALF = PORT_W / 2;

   // R6
   reset_defaults_chk: assert property (@(posedge clk)
      !rst_n |=> (out_q == '1 && pol_q == '0 && cfg_q == '1 && !sda_oe));

   // R11
   sda_rise_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   // R11
   sda_fall_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sda_oe) |-> !scl_i);

   // R3
   one_byte_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(!$stable(out_q[HALF-1:0]) && !$stable(out_q[PORT_W-1:HALF])));

   // R3
   one_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({!$stable(out_q), !$stable(pol_q), !$stable(cfg_q)}) <= 1);

   // R9
   reg_update_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(out_q) || !$stable(pol_q) || !$stable(cfg_q)) |-> !scl_i);
endmodule

bind gpx_i2c_target gpx_i2c_target_chk #(.PORT_W(PORT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q));

// File: tb/gpx_i2c_target_bench.sv
`timescale 1ns/1ps
module gpx_i2c_target_bench;
   localparam int Q = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1;
   logic        sda_m = 1'b1;
   logic [1:0]  strap = 2'b10;
   logic [15:0] pins = 16'h0000;
   logic        sda_oe;
   logic [15:0] out_q, pol_q, cfg_q;
   logic        sda_bus;

   int checks = 0;
   int errors = 0;

   logic [15:0] m_out = 16'hFFFF;
   logic [15:0] m_pol = 16'h0000;
   logic [15:0] m_cfg = 16'hFFFF;
   logic [7:0]  wbuf [16];

   assign sda_bus = sda_m & ~sda_oe;

   always #10 clk = ~clk;

   gpx_i2c_target u_gpx_i2c_target (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
      .strap_i(strap), .pin_i(pins), .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q));

   function automatic logic [6:0] my_addr();
      return {5'b11101, strap};
   endfunction

   function automatic logic [7:0] exp_reg(input logic [2:0] r);
      logic [15:0] v;
      case (r[2:1])
         2'd0:    v = pins ^ m_pol;
         2'd1:    v = m_out;
         2'd2:    v = m_pol;
         default: v = m_cfg;
      endcase
      return r[0] ? v[15:8] : v[7:0];
   endfunction

   function automatic void model_write(input logic [2:0] r, input logic [7:0] b);
      case (r)
         3'd2: m_out[7:0]  = b;
         3'd3: m_out[15:8] = b;
         3'd4: m_pol[7:0]  = b;
         3'd5: m_pol[15:8] = b;
         3'd6: m_cfg[7:0]  = b;
         3'd7: m_cfg[15:8] = b;
         default: ;
      endcase
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic waitq(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      sda_m = 1'b0; waitq(Q);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      sda_m = 1'b1; waitq(Q);
   endtask

   task automatic put_bit(input logic b);
      sda_m = b; waitq(Q);
      scl_m = 1'b1; waitq(Q);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic get_bit(output logic b);
      sda_m = 1'b1; waitq(Q);
      scl_m = 1'b1; waitq(Q/2);
      b = sda_bus; waitq(Q - Q/2);
      scl_m = 1'b0; waitq(Q);
   endtask

   task automatic send_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(b);
      ack = ~b;
   endtask

   task automatic recv_byte(input logic last, output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         get_bit(b);
         v[i] = b;
      end
      put_bit(last);
   endtask

   task automatic bus_write(input logic [7:0] cmd, input int n, input string req);
      logic ack;
      logic [2:0] p;
      bus_start();
      send_byte({my_addr(), 1'b0}, ack);
      chk({req, " R1 addr ack"}, 16'(ack), 16'd1);
      send_byte(cmd, ack);
      chk({req, " R11 cmd ack"}, 16'(ack), 16'd1);
      p = cmd[2:0];
      for (int i = 0; i < n; i++) begin
         send_byte(wbuf[i], ack);
         chk({req, " R11 data ack"}, 16'(ack), 16'd1);
         model_write(p, wbuf[i]);
         p[0] = ~p[0];
      end
      bus_stop();
      waitq(4);
      chk({req, " R3 out_q"}, out_q, m_out);
      chk({req, " R3 pol_q"}, pol_q, m_pol);
      chk({req, " R3 cfg_q"}, cfg_q, m_cfg);
   endtask

   task automatic bus_read(input logic [7:0] cmd, input int n, input string req);
      logic ack;
      logic [7:0] v;
      logic [2:0] p;
      bus_start();
      send_byte({my_addr(), 1'b0}, ack);
      send_byte(cmd, ack);
      bus_start();
      send_byte({my_addr(), 1'b1}, ack);
      chk({req, " R4 read addr ack"}, 16'(ack), 16'd1);
      p = cmd[2:0];
      for (int i = 0; i < n; i++) begin
         recv_byte(i == n - 1, v);
         chk({req, " R4 read byte"}, 16'(v), 16'(exp_reg(p)));
         p[0] = ~p[0];
      end
      bus_stop();
      waitq(2);
      chk({req, " R11 released"}, 16'(sda_oe), 16'd0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int unsigned seed;
      logic ack;
      seed = $urandom(32'd4242);
      waitq(5);
      // R6: defaults while reset held
      chk("R6 out reset", out_q, 16'hFFFF);
      chk("R6 pol reset", pol_q, 16'h0000);
      chk("R6 cfg reset", cfg_q, 16'hFFFF);
      chk("R6 sda_oe reset", 16'(sda_oe), 16'd0);
      rst_n = 1'b1;
      pins = 16'hA55A;
      waitq(5);
      bus_read(8'h00, 3, "R7 pins no inversion");

      // R1: strap mismatch is not acknowledged
      bus_start();
      send_byte({5'b11101, 2'b01, 1'b0}, ack);
      chk("R1 wrong strap nack", 16'(ack), 16'd0);
      send_byte(8'h02, ack);
      send_byte(8'h00, ack);
      bus_stop();
      waitq(4);
      chk("R1 ignored transfer", out_q, m_out);
      strap = 2'b01;
      waitq(4);
      wbuf[0] = 8'h81;
      bus_write(8'h02, 1, "R1 new strap");
      strap = 2'b10;
      waitq(4);

      // R2: upper command bits ignored (0xFB selects 3)
      wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h7E;
      bus_write(8'hFB, 3, "R2 upper bits");
      chk("R2 out hi", out_q, 16'h7EC3);

      // R5: input registers not writable
      wbuf[0] = 8'h12; wbuf[1] = 8'h34; wbuf[2] = 8'h56;
      bus_write(8'h00, 3, "R5 input write");
      chk("R5 pol untouched", pol_q, 16'h0000);

      // R7 / R8: inversion on inputs only
      wbuf[0] = 8'hF0; wbuf[1] = 8'h0F;
      bus_write(8'h04, 2, "R7 set pol");
      pins = 16'h1234;
      waitq(4);
      bus_read(8'h01, 4, "R7 inverted input");
      pins = ~m_out;
      waitq(4);
      bus_read(8'h02, 2, "R8 out stored");
      bus_read(8'h07, 3, "R8 cfg stored");

      // R9: STOP after a byte, then a fresh command
      wbuf[0] = 8'hA5;
      bus_write(8'h04, 1, "R9 first");
      bus_start();
      send_byte({my_addr(), 1'b0}, ack);
      bus_stop();
      waitq(4);
      chk("R9 stop after addr", pol_q, m_pol);
      wbuf[0] = 8'h11;
      bus_write(8'h3C, 1, "R9 fresh command");
      chk("R9 pol lo", pol_q[7:0], 8'h11);

      // R10: reset in the middle of a byte
      bus_start();
      send_byte({my_addr(), 1'b0}, ack);
      send_byte(8'h06, ack);
      send_byte(8'h0F, ack);
      put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
      rst_n = 1'b0;
      waitq(3);
      chk("R10 out default", out_q, 16'hFFFF);
      chk("R10 pol default", pol_q, 16'h0000);
      chk("R10 cfg default", cfg_q, 16'hFFFF);
      chk("R10 sda released", 16'(sda_oe), 16'd0);
      rst_n = 1'b1;
      m_out = 16'hFFFF; m_pol = 16'h0000; m_cfg = 16'hFFFF;
      bus_stop();
      waitq(4);
      bus_read(8'h06, 2, "R10 after reset");

      // Random mix: R3 R4 R7 R8
      for (int it = 0; it < 40; it++) begin
         int op;
         int n;
         logic [7:0] cmd;
         op  = int'($urandom % 3);
         n   = 1 + int'($urandom % 5);
         cmd = 8'($urandom);
         if (op == 0) begin
            for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
            bus_write(cmd, n, "R3 random write");
         end else if (op == 1) begin
            bus_read(cmd, n, "R4 random read");
         end else begin
            pins = 16'($urandom);
            waitq(4);
         end
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule